// File: doc/BRIEF.md
# Twice-Rate Clock Phase Enable Bridge

This block carries parallel words between a base clock and a second clock at exactly twice its frequency. Both clocks come from one generator, so their phase relation is fixed. The block does not resynchronize anything. It derives a fast-domain enable that is high for the fast period that starts at each base rising edge and low for the following one. Every fast-domain register on a crossing path loads only on the fast edge that ends an enabled period. That edge falls in the middle of the base cycle, never on an active base edge, so a fraction of a nanosecond of skew between the two clock nets costs no setup or hold margin.

Base-to-fast words are captured at mid-cycle and then stay stable for a whole base period, with a one-fast-cycle strobe for each valid word. Fast-to-base words are launched at the same mid-cycle edge into a holding register, and the base domain samples that register at its next rising edge.

A parameter selects where the phase information comes from. The first source is a pair of registers in the base domain: one toggles on the rising edge and the other copies it on the falling edge, and their XOR gives the phase. The second source is the base clock itself, sampled by the fast clock as data.

Top module: `phase_enable_bridge`

## Requirements
- R1: In steady state `fast_en_o` is high during the fast period that begins at a base rising edge and low during the next one, so at mid fast period it equals the base clock level. It is never high for two fast periods in a row.
- R2: `EN_SRC` = 0 (toggle/copy XOR) and `EN_SRC` = 1 (sampled base clock) give the same `fast_en_o` waveform.
- R3: After `rst_ni` is released while the base clock is low, `fast_en_o` stays low through the whole first base cycle. It first rises at the fast edge that coincides with the second base rising edge.
- R4: While `rst_ni` is low, all outputs are 0.
- R5: `b2f_data_o` loads `b2f_data_i` only at the fast edge that ends an enabled period (mid base cycle). It then holds that value for a full base period, and changes of `b2f_data_i` at any other fast edge have no effect.
- R6: `b2f_stb_o` is high for exactly one fast period after each mid-cycle capture for which `b2f_vld_i` was 1, and stays low otherwise.
- R7: The fast-to-base launch register loads `f2b_vld_i`/`f2b_data_i` only at the enabled fast edge. A word presented only during the non-enabled fast period never reaches the base outputs.
- R8: The word and valid bit launched at a mid-cycle fast edge appear on `f2b_data_o`/`f2b_vld_o` at the next base rising edge and hold for one base cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base_i | input | 1 | Base clock |
| clk_fast_i | input | 1 | Clock at twice the base rate, same source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| b2f_vld_i | input | 1 | Base-domain word valid |
| b2f_data_i | input | DATA_W | Base-domain word to the fast domain |
| f2b_vld_i | input | 1 | Fast-domain word valid |
| f2b_data_i | input | DATA_W | Fast-domain word to the base domain |
| fast_en_o | output | 1 | Generated fast-domain phase enable |
| b2f_stb_o | output | 1 | One-fast-cycle strobe per captured valid word |
| b2f_data_o | output | DATA_W | Captured word, fast domain |
| f2b_vld_o | output | 1 | Valid of the word sampled in the base domain |
| f2b_data_o | output | DATA_W | Word sampled in the base domain |

## Verification
If the phase state is inverted or arrives late, `fast_en_o` falls out of step with the base clock level within one fast period. The capture edge then moves onto the base edge, where a skewed base clock makes the fast side read the new base word. A fast-to-base launch at the wrong edge overwrites the holding register just before the base edge samples it. The wrong word therefore shows on `f2b_data_o` within one base cycle. Startup gating errors show as an enable pulse in the first base cycle after reset.

// File: rtl/peb_pkg.sv
package peb_pkg;
  localparam int unsigned EN_SRC_XOR     = 0;
  localparam int unsigned EN_SRC_REPLICA = 1;
endpackage

// File: rtl/peb_phase_toggle.sv
module peb_phase_toggle (
  input  logic clk_base_i,
  input  logic rst_ni,
  output logic phase_o
);
  logic tog_q, copy_q;

  always_ff @(posedge clk_base_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(negedge clk_base_i or negedge rst_ni) begin
    if (!rst_ni) copy_q <= 1'b0;
    else         copy_q <= tog_q;
  end

  // high in the first half of every base cycle
  assign phase_o = tog_q ^ copy_q;

  assert_copy_tracks_R1: assert property (@(posedge clk_base_i) disable iff (!rst_ni)
    copy_q == tog_q);
endmodule

// File: rtl/peb_enable_gen.sv
module peb_enable_gen import peb_pkg::*; #(
  parameter int unsigned EN_SRC = EN_SRC_XOR
) (
  input  logic clk_fast_i,
  input  logic clk_base_i,
  input  logic rst_ni,
  output logic fast_en_o
);
  logic phase_raw;
  logic sample_q, seen_q;

  generate
    if (EN_SRC == EN_SRC_XOR) begin : g_xor
      peb_phase_toggle u_tog (
        .clk_base_i (clk_base_i),
        .rst_ni     (rst_ni),
        .phase_o    (phase_raw)
      );
    end else begin : g_replica
      assign phase_raw = clk_base_i;
    end
  endgenerate

  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      sample_q <= phase_raw;
      seen_q   <= seen_q | sample_q;
    end
  end

  // enabled in the fast period after a base edge; held low until a high phase was seen
  assign fast_en_o = seen_q & ~sample_q;

  assert_en_single_R1: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    fast_en_o |=> !fast_en_o);
  assert_en_alternates_R1: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    (seen_q && !fast_en_o) |=> fast_en_o);
endmodule

// File: rtl/peb_up_capture.sv
module peb_up_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_fast_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stb_o,
  output logic [DATA_W-1:0] data_o
);
  logic              stb_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      data_q <= '0;
    end else begin
      stb_q <= en_i & vld_i;
      if (en_i) data_q <= data_i;
    end
  end

  assign stb_o  = stb_q;
  assign data_o = data_q;

  assert_hold_off_edge_R5: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_q));
  assert_stb_single_R6: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
endmodule

// File: rtl/peb_down_launch.sv
module peb_down_launch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_fast_i,
  input  logic              clk_base_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  logic              l_vld_q, b_vld_q;
  logic [DATA_W-1:0] l_data_q, b_data_q;

  // fast side: launch only at the mid-cycle edge
  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_vld_q  <= 1'b0;
      l_data_q <= '0;
    end else if (en_i) begin
      l_vld_q  <= vld_i;
      l_data_q <= data_i;
    end
  end

  // base side: sample the held launch register
  always_ff @(posedge clk_base_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_vld_q  <= 1'b0;
      b_data_q <= '0;
    end else begin
      b_vld_q  <= l_vld_q;
      b_data_q <= l_data_q;
    end
  end

  assign vld_o  = b_vld_q;
  assign data_o = b_data_q;

  assert_launch_hold_R7: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    !en_i |=> $stable({l_vld_q, l_data_q}));
endmodule

// File: rtl/phase_enable_bridge.sv
module phase_enable_bridge import peb_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_SRC = EN_SRC_XOR
) (
  input  logic              clk_base_i,
  input  logic              clk_fast_i,
  input  logic              rst_ni,
  input  logic              b2f_vld_i,
  input  logic [DATA_W-1:0] b2f_data_i,
  input  logic              f2b_vld_i,
  input  logic [DATA_W-1:0] f2b_data_i,
  output logic              fast_en_o,
  output logic              b2f_stb_o,
  output logic [DATA_W-1:0] b2f_data_o,
  output logic              f2b_vld_o,
  output logic [DATA_W-1:0] f2b_data_o
);
  logic en;

  peb_enable_gen #(.EN_SRC(EN_SRC)) u_en (
    .clk_fast_i (clk_fast_i),
    .clk_base_i (clk_base_i),
    .rst_ni     (rst_ni),
    .fast_en_o  (en)
  );

  peb_up_capture #(.DATA_W(DATA_W)) u_up (
    .clk_fast_i (clk_fast_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .vld_i      (b2f_vld_i),
    .data_i     (b2f_data_i),
    .stb_o      (b2f_stb_o),
    .data_o     (b2f_data_o)
  );

  peb_down_launch #(.DATA_W(DATA_W)) u_down (
    .clk_fast_i (clk_fast_i),
    .clk_base_i (clk_base_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .vld_i      (f2b_vld_i),
    .data_i     (f2b_data_i),
    .vld_o      (f2b_vld_o),
    .data_o     (f2b_data_o)
  );

  assign fast_en_o = en;

  assert_reset_quiet_R4: assert property (@(posedge clk_fast_i)
    !rst_ni |-> (!en && !b2f_stb_o && b2f_data_o == '0));
endmodule

// File: tb/phase_enable_bridge_tb.sv
`timescale 1ns/1ps
module phase_enable_bridge_tb;
  localparam int FAST_PERIOD = 10;
  localparam int HALF        = FAST_PERIOD / 2;
  localparam int SKEW        = 1;   // base net lags fast net
  localparam int DW          = 8;
  localparam int STEPS       = 600;

  logic clk_fast = 1'b0, clk_base = 1'b0, rst_n = 1'b0;
  logic b2f_vld = 1'b0, f2b_vld = 1'b0;
  logic [DW-1:0] b2f_data = '0, f2b_data = '0;
  logic en_a, stb_a, fv_a, en_b, stb_b, fv_b;
  logic [DW-1:0] bd_a, fd_a, bd_b, fd_b;

  int checks = 0, fails = 0;
  bit done = 0;

  phase_enable_bridge #(.DATA_W(DW), .EN_SRC(0)) u_dut (
    .clk_base_i(clk_base), .clk_fast_i(clk_fast), .rst_ni(rst_n),
    .b2f_vld_i(b2f_vld), .b2f_data_i(b2f_data), .f2b_vld_i(f2b_vld), .f2b_data_i(f2b_data),
    .fast_en_o(en_a), .b2f_stb_o(stb_a), .b2f_data_o(bd_a), .f2b_vld_o(fv_a), .f2b_data_o(fd_a));

  phase_enable_bridge #(.DATA_W(DW), .EN_SRC(1)) u_dut_rep (
    .clk_base_i(clk_base), .clk_fast_i(clk_fast), .rst_ni(rst_n),
    .b2f_vld_i(b2f_vld), .b2f_data_i(b2f_data), .f2b_vld_i(f2b_vld), .f2b_data_i(f2b_data),
    .fast_en_o(en_b), .b2f_stb_o(stb_b), .b2f_data_o(bd_b), .f2b_vld_o(fv_b), .f2b_data_o(fd_b));

  initial forever #HALF clk_fast = ~clk_fast;
  initial begin
    #(HALF + SKEW);
    forever begin
      clk_base = 1'b1; #FAST_PERIOD;
      clk_base = 1'b0; #FAST_PERIOD;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(FAST_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit warm = 1;
    bit have_up = 0, have_dn = 0;
    logic [DW-1:0] up_data = '0, dn_data = '0;
    logic up_vld = 0, dn_vld = 0;
    int seq = 0;

    // R4: outputs quiet in reset
    repeat (4) begin
      @(negedge clk_fast);
      chk("R4 en", {en_a, en_b}, 0);
      chk("R4 outs", {stb_a, bd_a, fv_a, fd_a, stb_b, bd_b, fv_b, fd_b}, 0);
    end
    while (clk_base !== 1'b0) @(negedge clk_fast);
    rst_n = 1'b1;

    for (int i = 0; i < STEPS; i++) begin
      @(negedge clk_fast);
      if (warm) begin
        if (clk_base) begin
          chk("R3 startup en", {en_a, en_b}, 0);
          warm = 0;
        end
        continue;
      end
      chk("R1 en phase", en_a, clk_base);
      chk("R2 en sources", en_b, en_a);
      if (clk_base) begin
        chk("R6 stb idle", {stb_a, stb_b}, 0);
        if (have_up) begin
          chk("R5 hold", bd_a, up_data);
          chk("R5 hold rep", bd_b, up_data);
        end
        if (have_dn) begin
          chk("R8 f2b vld", {fv_a, fv_b}, {dn_vld, dn_vld});
          chk("R8 f2b data", {fd_a, fd_b}, {dn_data, dn_data});
        end
        seq++;
        up_data = DW'(seq * 37 + 5);
        up_vld  = (seq % 3) != 0;
        dn_data = DW'(seq * 53) ^ DW'(8'hA5);
        dn_vld  = (seq % 4) != 1;
        b2f_data = up_data; b2f_vld = up_vld;
        f2b_data = dn_data; f2b_vld = dn_vld;
        have_up = 1; have_dn = 1;
      end else begin
        if (have_up) begin
          chk("R6 stb", {stb_a, stb_b}, {up_vld, up_vld});
          chk("R5 capture", {bd_a, bd_b}, {up_data, up_data});
        end
        // junk presented only in the non-enabled period: R5 and R7 say ignored
        b2f_data = ~up_data; b2f_vld = ~up_vld;
        f2b_data = ~dn_data; f2b_vld = ~dn_vld;
      end
    end
    finish_run();
  end
endmodule